// File: doc/BRIEF.md
# Pad Configuration Register with Selectable Reset Domain

This block holds the configuration word of one general-purpose I/O pad together with a lock bit. The top two bits of the word form a reset-select field. At run time that field chooses which platform reset events put the configuration back to its default value. A parameter picks the well the pad lives in: a primary-well pad or a deep-sleep-well pad. The two wells map the same select code to different sets of events.

The lock bit follows a different rule. Its reset domain is fixed to the pad well's power-good domain, and the select field has no effect on it. When the select field names a wider reset domain than power-good, a reset can return the configuration to its default while the pad stays locked. Software then cannot reprogram the pad. The block raises a status output whenever it is in this state.

Platform events arrive as one-cycle pulses. The write port loads a full word. A lock request sets the lock bit.

Top module: `gpio_pad_cfg_reg`

## Requirements
- R1: After the synchronous active-low reset, the configuration equals CFG_DEFAULT, the lock is clear and the mismatch flag is low.
- R2: With the lock clear, a write loads the full word in the next cycle, including the select field in bits [31:30].
- R3: Select code 00 (power-good) resets a primary-well pad on deep-sleep entry or power loss only. It resets a deep-sleep-well pad on power loss only.
- R4: Select code 01 (deep) resets either pad type on warm, cold, global, deep-sleep or power-loss events. It does not reset on S3/S4/S5 sleep entry.
- R5: Select code 10 (host) resets either pad type on every one of the six events.
- R6: Select code 11 resets a deep-sleep-well pad on deep-sleep entry or power loss. On a primary-well pad the code is reserved: a write still stores it, and the pad then resets as for code 00.
- R7: A lock request sets the lock in the next cycle. No write clears it. It clears only on its power-good domain, whatever the select field holds: deep-sleep entry or power loss for a primary-well pad, power loss only for a deep-sleep-well pad.
- R8: While the lock is set, a write leaves the bits under LOCK_MASK (default 0xFFFFFF00) unchanged and still updates the other bits. This holds right after a reset has restored the default.
- R9: When a reset event that applies to the current select code arrives in the same cycle as a write, the configuration takes its default value.
- R10: The mismatch flag is high exactly when the lock is set, the configuration equals CFG_DEFAULT and the select field is not 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_warm | input | 1 | Warm reset pulse |
| evt_cold | input | 1 | Cold reset pulse |
| evt_sleep | input | 1 | S3/S4/S5 sleep entry pulse |
| evt_global | input | 1 | Global reset pulse |
| evt_deep | input | 1 | Deep-sleep entry pulse |
| evt_g3 | input | 1 | Full power loss pulse |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data |
| lock_req | input | 1 | Lock-set request |
| cfg_q | output | DATA_W | Current configuration word |
| locked | output | 1 | Lock status |
| lock_mismatch | output | 1 | Default configuration still locked, select not 00 |

## Verification
For each of the four select codes, the bench loads a payload word and then fires each of the six events alone. It runs this on a primary-well and a deep-sleep-well instance side by side, so each cell of the event map is confirmed as reset or kept for both wells. A lock sequence sets the lock and fires a warm reset under code 01, which separates the configuration's reset domain from the lock's. It then fires deep-sleep entry, which separates the two wells' power-good domains. A write that arrives in the same cycle as a reset shows which of the two wins.

// File: rtl/gpio_pad_pkg.sv
// Shared types for the pad configuration register.
// Assumes event pulses are one cycle wide and synchronous to clk.
package gpio_pad_pkg;

    typedef enum logic [1:0] {
        RSEL_PWRGOOD = 2'b00,
        RSEL_DEEP    = 2'b01,
        RSEL_HOST    = 2'b10,
        RSEL_RESUME  = 2'b11
    } rsel_e;

    typedef struct packed {
        logic warm;
        logic cold;
        logic sleep;
        logic glob;
        logic deep;
        logic g3;
    } plat_evt_t;

endpackage

// File: rtl/gpio_pad_rst_decode.sv
// Maps the reset-select code and the platform events to two reset strobes:
// one for the configuration word and one for the lock bit.
// IS_DSW selects the deep-sleep-well mapping; otherwise the primary-well mapping.
// Assumes all inputs are synchronous to the register clock.
module gpio_pad_rst_decode
    import gpio_pad_pkg::*;
#(
    parameter bit IS_DSW = 1'b0
) (
    input  logic [1:0] sel,
    input  plat_evt_t  evt,
    output logic       cfg_rst,
    output logic       lock_rst
);

    logic pg_evt;
    logic deep_evt;
    logic resume_evt;

    // Power-good domain of this well; this is the fixed domain of the lock bit.
    generate
        if (IS_DSW) begin : g_dsw
            assign pg_evt     = evt.g3;
            assign resume_evt = evt.deep | evt.g3;
        end else begin : g_primary
            assign pg_evt     = evt.deep | evt.g3;
            // Code 11 is reserved on this well and behaves as power-good.
            assign resume_evt = evt.deep | evt.g3;
        end
    endgenerate

    // Deep domain: every event except sleep entry.
    assign deep_evt = evt.warm | evt.cold | evt.glob | evt.deep | evt.g3;

    // Select which domain resets the configuration word.
    always_comb begin
        case (rsel_e'(sel))
            RSEL_PWRGOOD: cfg_rst = pg_evt;
            RSEL_DEEP:    cfg_rst = deep_evt;
            RSEL_HOST:    cfg_rst = deep_evt | evt.sleep;
            default:      cfg_rst = resume_evt;
        endcase
    end

    assign lock_rst = pg_evt;

endmodule

// File: rtl/gpio_pad_lock_ctl.sv
// Lock bit of the pad. It is set by a request and cleared only by its
// power-good domain strobe or by the block reset. No write port reaches it.
module gpio_pad_lock_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_rst,
    input  logic lock_req,
    output logic locked
);

    // Hold the lock; a domain reset wins over a same-cycle request.
    always_ff @(posedge clk) begin
        if (!rst_n || lock_rst) begin
            locked <= 1'b0;
        end else if (lock_req) begin
            locked <= 1'b1;
        end
    end

    assert_lock_sticky_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !lock_rst) |=> locked);

    assert_lock_clear_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        lock_rst |=> !locked);

endmodule

// File: rtl/gpio_pad_cfg_store.sv
// Configuration word storage. A reset strobe restores CFG_DEFAULT and wins
// over a same-cycle write. While locked, bits under LOCK_MASK ignore writes.
module gpio_pad_cfg_store #(
    parameter int              DATA_W      = 32,
    parameter logic [DATA_W-1:0] CFG_DEFAULT = '0,
    parameter logic [DATA_W-1:0] LOCK_MASK   = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              locked,
    output logic [DATA_W-1:0] cfg_q
);

    logic [DATA_W-1:0] wr_mask;

    // Bits a write may change in this cycle.
    assign wr_mask = locked ? ~LOCK_MASK : {DATA_W{1'b1}};

    // Update the word: reset first, then masked write.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_rst) begin
            cfg_q <= CFG_DEFAULT;
        end else if (wr_en) begin
            cfg_q <= (cfg_q & ~wr_mask) | (wr_data & wr_mask);
        end
    end

    assert_rst_wins_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rst |=> (cfg_q == CFG_DEFAULT));

    assert_locked_bits_hold_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !cfg_rst) |=> ((cfg_q & LOCK_MASK) == ($past(cfg_q) & LOCK_MASK)));

endmodule

// File: rtl/gpio_pad_cfg_reg.sv
// Pad configuration register with a run-time selectable reset domain and a
// lock bit tied to the well's power-good domain. The select field sits in the
// top two bits of the word. lock_mismatch flags a default word that is still
// locked while the select field names a domain other than power-good.
module gpio_pad_cfg_reg
    import gpio_pad_pkg::*;
#(
    parameter int                DATA_W      = 32,
    parameter bit                IS_DSW      = 1'b0,
    parameter logic [DATA_W-1:0] CFG_DEFAULT = 32'h4000_0200,
    parameter logic [DATA_W-1:0] LOCK_MASK   = 32'hFFFF_FF00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_warm,
    input  logic              evt_cold,
    input  logic              evt_sleep,
    input  logic              evt_global,
    input  logic              evt_deep,
    input  logic              evt_g3,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              lock_req,
    output logic [DATA_W-1:0] cfg_q,
    output logic              locked,
    output logic              lock_mismatch
);

    localparam int SEL_LSB = DATA_W - 2;

    plat_evt_t   evt;
    logic [1:0]  sel;
    logic        cfg_rst;
    logic        lock_rst;

    // Gather the event pulses into one bundle.
    assign evt = '{warm: evt_warm, cold: evt_cold, sleep: evt_sleep,
                   glob: evt_global, deep: evt_deep, g3: evt_g3};

    assign sel = cfg_q[DATA_W-1:SEL_LSB];

    gpio_pad_rst_decode #(.IS_DSW(IS_DSW)) u_decode (
        .sel      (sel),
        .evt      (evt),
        .cfg_rst  (cfg_rst),
        .lock_rst (lock_rst)
    );

    gpio_pad_lock_ctl u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_rst (lock_rst),
        .lock_req (lock_req),
        .locked   (locked)
    );

    gpio_pad_cfg_store #(
        .DATA_W      (DATA_W),
        .CFG_DEFAULT (CFG_DEFAULT),
        .LOCK_MASK   (LOCK_MASK)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_rst (cfg_rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .locked  (locked),
        .cfg_q   (cfg_q)
    );

    // Flag a default word that software can no longer reprogram.
    assign lock_mismatch = locked && (cfg_q == CFG_DEFAULT) && (sel != 2'b00);

    initial assert (DATA_W >= 2) else $error("DATA_W too small");

    assert_sleep_kept_deep_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b01 && evt_sleep && !evt_warm && !evt_cold && !evt_global
         && !evt_deep && !evt_g3 && !wr_en) |=> $stable(cfg_q));

    assert_host_sleep_resets_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b10 && evt_sleep) |=> (cfg_q == CFG_DEFAULT));

    assert_warm_keeps_lock_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        (locked && evt_warm && !evt_deep && !evt_g3) |=> locked);

endmodule

// File: tb/test_gpio_pad_cfg_reg.sv
module test_gpio_pad_cfg_reg;

    localparam logic [31:0] DEF  = 32'h4000_0200;
    localparam logic [31:0] MASK = 32'hFFFF_FF00;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  evt;
    logic        wr_en;
    logic [31:0] wr_data;
    logic        lock_req;
    logic [31:0] cfg_p, cfg_d;
    logic        lock_p, lock_d, mm_p, mm_d;
    int          checks = 0;
    int          errors = 0;

    always #4 clk = ~clk;

    gpio_pad_cfg_reg #(.IS_DSW(1'b0)) i_gpio_pad_cfg_reg (
        .clk(clk), .rst_n(rst_n), .evt_warm(evt[0]), .evt_cold(evt[1]),
        .evt_sleep(evt[2]), .evt_global(evt[3]), .evt_deep(evt[4]), .evt_g3(evt[5]),
        .wr_en(wr_en), .wr_data(wr_data), .lock_req(lock_req),
        .cfg_q(cfg_p), .locked(lock_p), .lock_mismatch(mm_p));

    gpio_pad_cfg_reg #(.IS_DSW(1'b1)) i_gpio_pad_cfg_reg_dsw (
        .clk(clk), .rst_n(rst_n), .evt_warm(evt[0]), .evt_cold(evt[1]),
        .evt_sleep(evt[2]), .evt_global(evt[3]), .evt_deep(evt[4]), .evt_g3(evt[5]),
        .wr_en(wr_en), .wr_data(wr_data), .lock_req(lock_req),
        .cfg_q(cfg_d), .locked(lock_d), .lock_mismatch(mm_d));

    // Event index: 0 warm, 1 cold, 2 sleep, 3 global, 4 deep, 5 power loss.
    function automatic bit exp_rst(bit dsw, int sel, int ev);
        case (sel)
            0:       return dsw ? (ev == 5) : (ev >= 4);
            1:       return ev != 2;
            2:       return 1'b1;
            default: return ev >= 4;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; evt = '0; wr_en = 1'b0; wr_data = '0; lock_req = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_word(logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_evt(int ev);
        @(negedge clk);
        evt = 6'b1 << ev;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic pulse_lock();
        @(negedge clk);
        lock_req = 1'b1;
        @(negedge clk);
        lock_req = 1'b0;
    endtask

    task automatic test_reset_state();
        do_reset();
        check("R1 cfg", cfg_p, DEF);
        check("R1 cfg dsw", cfg_d, DEF);
        check("R1 lock", {30'b0, lock_p, lock_d}, 32'h0);
        check("R1 mismatch", {30'b0, mm_p, mm_d}, 32'h0);
    endtask

    task automatic test_event_map();
        for (int s = 0; s < 4; s++) begin
            for (int e = 0; e < 6; e++) begin
                logic [31:0] w;
                w = {s[1:0], 30'h0A5A_5A3C};
                write_word(w);
                check("R2 write", cfg_p, w);
                pulse_evt(e);
                // R3 R4 R5 R6 per select code
                check($sformatf("R3-6 primary sel=%0d ev=%0d", s, e), cfg_p,
                      exp_rst(1'b0, s, e) ? DEF : w);
                check($sformatf("R3-6 dsw sel=%0d ev=%0d", s, e), cfg_d,
                      exp_rst(1'b1, s, e) ? DEF : w);
            end
        end
    endtask

    task automatic test_lock_sequence();
        logic [31:0] w1;
        do_reset();
        w1 = {2'b01, 30'h0A5A_5A3C};
        write_word(w1);
        pulse_lock();
        check("R7 lock set", {30'b0, lock_p, lock_d}, 32'h3);
        write_word(32'h8000_00FF);
        check("R8 masked write", cfg_p, (w1 & MASK) | 32'hFF);
        check("R7 write no unlock", {30'b0, lock_p, lock_d}, 32'h3);
        pulse_evt(0);
        check("R7 warm keeps lock", {30'b0, lock_p, lock_d}, 32'h3);
        check("R10 mismatch after warm", {30'b0, mm_p, mm_d}, 32'h3);
        write_word(32'h0000_0011);
        check("R8 locked after default", cfg_p, 32'h4000_0211);
        check("R10 mismatch off", {30'b0, mm_p, mm_d}, 32'h0);
        write_word(32'h0000_0000);
        check("R10 mismatch back", {30'b0, mm_p, mm_d}, 32'h3);
        pulse_evt(4);
        check("R7 deep lock", {30'b0, lock_p, lock_d}, 32'h1);
        check("R10 deep mismatch", {30'b0, mm_p, mm_d}, 32'h1);
        pulse_evt(5);
        check("R7 g3 lock", {30'b0, lock_p, lock_d}, 32'h0);
    endtask

    task automatic test_reset_beats_write();
        do_reset();
        write_word({2'b10, 30'h0123_4567});
        @(negedge clk);
        evt = 6'b000001; wr_en = 1'b1; wr_data = 32'h1234_5678;
        @(negedge clk);
        evt = '0; wr_en = 1'b0;
        check("R9 primary", cfg_p, DEF);
        check("R9 dsw", cfg_d, DEF);
    endtask

    initial begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; evt = '0; wr_en = 1'b0; wr_data = '0; lock_req = 1'b0;
        test_reset_state();
        test_event_map();
        test_lock_sequence();
        test_reset_beats_write();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule